// File: doc/BRIEF.md
# PCM Highway Time-Slot Interchange

This block is an eight-by-eight time-division switch for 8-bit voice and data channels. Each channel carries one octet per 8 kHz frame. Four input channels are taken from time slots 0 to 3 of a serial receive highway. The other four input channels come in parallel from internal endpoints: two data channels and two line B channels. On the output side, four channels are shifted out in time slots 0 to 3 of a serial transmit highway, and four are presented in parallel to internal endpoints.

Every output channel has its own route setting. The setting holds an enable flag and the number of the input channel that feeds the output. Because of this, one input can feed several outputs at once, for example a voice channel sent to a highway slot and to a monitoring sink. Each highway has its own bit clock, which runs at 64 kHz times the number of slots (8 to 32 slots per frame). Each highway also has its own frame sync. The block oversamples both bit clocks with the system clock. Octets collected during one frame are sent out during the next frame.

Top module: `pcm_tsi`

## Requirements
- R1: While reset is high and after it is released, with no frame sync yet seen, `tx_data` is 1, `tx_en` is 0 and every internal output octet is 0xFF.
- R2: Receive data is sampled on falling edges of `rx_bclk`. A falling edge with `rx_fsync` high marks the last bit of a frame. The next falling edge samples bit 7 (MSB) of slot 0. Slot k carries bit positions 8k to 8k+7, MSB first, and slots 0 to 3 form input channels 0 to 3.
- R3: The octets of input channels 0 to 7 are fixed for a frame when that frame's closing sync is sampled. Highway octets are the ones received during the frame. An internal input (channel 4+i, `int_in[8i+7:8i]`) is the value sampled on the falling edge that opened the frame. These octets appear on the outputs during the next transmit frame.
- R4: Output channel o is set by `route_cfg[4o+3:4o]`. Bit 3 is the enable flag and bits 2:0 give the source input channel. An enabled output carries that source. Output channels 0 to 3 go out in transmit slots 0 to 3. Each bit is driven MSB first from the rising `tx_bclk` edge, with `tx_en` high. Output channel 4+i appears on `int_out[8i+7:8i]`.
- R5: One input may feed any number of outputs in the same frame, and each of those outputs carries the same octet.
- R6: An output with its enable flag clear carries 0xFF. In its highway slot, `tx_en` is 0 and `tx_data` is 1.
- R7: In transmit slots 4 and above, `tx_en` is 0 and `tx_data` is 1.
- R8: `route_cfg` is sampled only on the first rising `tx_bclk` edge after a falling edge that saw `tx_fsync` high, which is the frame start. A change in the middle of a frame does not alter any octet of that frame.
- R9: `int_out` changes only at a transmit frame start and holds its value for the rest of the frame.
- R10: Frame length follows the frame sync. Frames of 8, 16 and 32 slots switch correctly, and frames of different lengths may follow one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples both highway bit clocks |
| rst | input | 1 | Synchronous active-high reset |
| rx_bclk | input | 1 | Receive highway bit clock |
| rx_fsync | input | 1 | Receive frame sync, high during the last bit of a frame |
| rx_data | input | 1 | Receive highway serial data |
| int_in | input | 32 | Internal input channels 4 to 7, one octet each, channel 4 in the low byte |
| route_cfg | input | 32 | Route setting per output: {enable, source[2:0]} per nibble, output 0 in the low nibble |
| tx_bclk | input | 1 | Transmit highway bit clock |
| tx_fsync | input | 1 | Transmit frame sync, high during the last bit of a frame |
| tx_data | output | 1 | Transmit highway serial data, 1 when idle |
| tx_en | output | 1 | High while a routed slot is being driven |
| int_out | output | 32 | Internal output channels 4 to 7, channel 4 in the low byte |

## Verification
A highway bit sampled on a falling `rx_bclk` edge is taken on the first system clock edge that sees the bit clock low. It can only appear at the outputs one frame later. A transmit bit and its `tx_en` change on the first system clock edge that sees `tx_bclk` high, and `int_out` moves on that same edge for the first bit of a frame. The bench drives every input on the falling system clock edge. It updates its behavioural model at the same moment for the value due at the next rising edge, and it compares all outputs on every falling edge. Any result early or late by a single system cycle is therefore reported.

// File: rtl/pcm_tsi_pkg.sv
`timescale 1ns/1ps
package pcm_tsi_pkg;
    localparam int OCT_W     = 8;
    localparam int N_CH      = 8;
    localparam int HW_CH     = 4;
    localparam int INT_CH    = N_CH - HW_CH;
    localparam int MAX_SLOTS = 32;
    localparam int SRC_W     = $clog2(N_CH);
    localparam int BIT_W     = $clog2(OCT_W);
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int HSEL_W    = $clog2(HW_CH);
    localparam int POS_W     = SLOT_W + BIT_W;
    localparam int RT_W      = SRC_W + 1;

    typedef logic [OCT_W-1:0] octet_t;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } route_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bpos;
    } hw_pos_t;

    localparam octet_t            IDLE_OCT = '1;
    localparam logic [SLOT_W-1:0] HW_SLOTS = SLOT_W'(HW_CH);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(OCT_W - 1);

    // advance a highway bit position, saturating on over-long frames
    function automatic hw_pos_t pos_step(input hw_pos_t p);
        logic [POS_W-1:0] v;
        v = p;
        if (v != '1) v = v + POS_W'(1);
        return hw_pos_t'(v);
    endfunction

    function automatic octet_t route_pick(input route_t r, input octet_t [N_CH-1:0] bank);
        return r.en ? bank[r.src] : IDLE_OCT;
    endfunction
endpackage

// File: rtl/tsi_rx_bank.sv
`timescale 1ns/1ps
module tsi_rx_bank
    import pcm_tsi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bclk,
    input  logic                   fsync,
    input  logic                   sdata,
    input  octet_t [INT_CH-1:0]    int_in,
    output octet_t [N_CH-1:0]      bank
);
    logic                 bclk_q, first_q, lock_q, fall, word_done;
    hw_pos_t              pos_q, pos_n;
    logic [OCT_W-2:0]     sr_q;
    octet_t               word;
    octet_t [N_CH-1:0]    stage_q, hold_q;

    always_comb begin
        fall      = bclk_q & ~bclk;
        word      = {sr_q, sdata};
        pos_n     = first_q ? '0 : pos_step(pos_q);
        word_done = lock_q && !fsync && (pos_n.bpos == LAST_BIT) && (pos_n.slot < HW_SLOTS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            first_q <= 1'b0;
            lock_q  <= 1'b0;
            pos_q   <= '1;
            sr_q    <= '0;
            stage_q <= {N_CH{IDLE_OCT}};
            hold_q  <= {N_CH{IDLE_OCT}};
        end else begin
            bclk_q <= bclk;
            if (fall) begin
                sr_q <= word[OCT_W-2:0];
                if (fsync) begin
                    first_q <= 1'b1;
                    lock_q  <= 1'b1;
                    hold_q  <= stage_q;
                    for (int i = 0; i < INT_CH; i++) stage_q[HW_CH+i] <= int_in[i];
                end else begin
                    first_q <= 1'b0;
                    pos_q   <= pos_n;
                    if (word_done) stage_q[SRC_W'(pos_n.slot[HSEL_W-1:0])] <= word;
                end
            end
        end
    end

    assign bank = hold_q;

    // R3
    hold_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(hold_q) |-> $past(fall && fsync));
endmodule

// File: rtl/tsi_xpoint.sv
`timescale 1ns/1ps
module tsi_xpoint
    import pcm_tsi_pkg::*;
(
    input  route_t [N_CH-1:0] route,
    input  octet_t [N_CH-1:0] bank,
    output octet_t [N_CH-1:0] pick
);
    for (genvar o = 0; o < N_CH; o++) begin : g_out
        assign pick[o] = route_pick(route[o], bank);
    end
endmodule

// File: rtl/tsi_tx_frame.sv
`timescale 1ns/1ps
module tsi_tx_frame
    import pcm_tsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                fsync,
    input  logic [HW_CH-1:0]    route_en,
    input  octet_t [N_CH-1:0]   pick,
    output logic                sdata,
    output logic                sen,
    output octet_t [INT_CH-1:0] int_out
);
    logic                 bclk_q, arm_q, lock_q;
    logic                 rise, fall, load, live, in_hw, drive, bit_val;
    hw_pos_t              pos_q, pos_n;
    logic [HW_CH-1:0]     en_q, cur_en;
    octet_t [HW_CH-1:0]   oct_q, cur_oct;
    octet_t [INT_CH-1:0]  int_q;
    logic [HSEL_W-1:0]    hs;

    always_comb begin
        rise  = ~bclk_q & bclk;
        fall  = bclk_q & ~bclk;
        load  = rise & arm_q;
        pos_n = load ? '0 : pos_step(pos_q);
        for (int h = 0; h < HW_CH; h++) begin
            cur_oct[h] = load ? pick[h] : oct_q[h];
            cur_en[h]  = load ? route_en[h] : en_q[h];
        end
        hs      = pos_n.slot[HSEL_W-1:0];
        in_hw   = pos_n.slot < HW_SLOTS;
        live    = lock_q | load;
        drive   = live & in_hw & cur_en[hs];
        bit_val = cur_oct[hs][LAST_BIT - pos_n.bpos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            arm_q  <= 1'b0;
            lock_q <= 1'b0;
            pos_q  <= '1;
            en_q   <= '0;
            oct_q  <= {HW_CH{IDLE_OCT}};
            int_q  <= {INT_CH{IDLE_OCT}};
            sdata  <= 1'b1;
            sen    <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (fall && fsync) arm_q <= 1'b1;
            if (rise) begin
                pos_q <= pos_n;
                sen   <= drive;
                sdata <= drive ? bit_val : 1'b1;
            end
            if (load) begin
                arm_q  <= 1'b0;
                lock_q <= 1'b1;
                en_q   <= route_en;
                oct_q  <= pick[HW_CH-1:0];
                int_q  <= pick[N_CH-1:HW_CH];
            end
        end
    end

    assign int_out = int_q;

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !sen |-> sdata);
    // R7
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        sen |-> (pos_q.slot < HW_SLOTS));
    // R4
    routed_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sen |-> en_q[pos_q.slot[HSEL_W-1:0]]);
    // R8
    route_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> $past(load));
    // R9
    int_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(int_q) |-> $past(load));
endmodule

// File: rtl/pcm_tsi.sv
`timescale 1ns/1ps
module pcm_tsi
    import pcm_tsi_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_bclk,
    input  logic                      rx_fsync,
    input  logic                      rx_data,
    input  logic [INT_CH*OCT_W-1:0]   int_in,
    input  logic [N_CH*RT_W-1:0]      route_cfg,
    input  logic                      tx_bclk,
    input  logic                      tx_fsync,
    output logic                      tx_data,
    output logic                      tx_en,
    output logic [INT_CH*OCT_W-1:0]   int_out
);
    route_t [N_CH-1:0]   cfg;
    octet_t [N_CH-1:0]   bank, pick;
    octet_t [INT_CH-1:0] int_in_w, int_out_w;
    logic [HW_CH-1:0]    hw_en;

    assign cfg      = route_cfg;
    assign int_in_w = int_in;
    assign int_out  = int_out_w;

    for (genvar h = 0; h < HW_CH; h++) begin : g_en
        assign hw_en[h] = cfg[h].en;
    end

    tsi_rx_bank u_rx (
        .clk    (clk),
        .rst    (rst),
        .bclk   (rx_bclk),
        .fsync  (rx_fsync),
        .sdata  (rx_data),
        .int_in (int_in_w),
        .bank   (bank)
    );

    tsi_xpoint u_xp (
        .route (cfg),
        .bank  (bank),
        .pick  (pick)
    );

    tsi_tx_frame u_tx (
        .clk      (clk),
        .rst      (rst),
        .bclk     (tx_bclk),
        .fsync    (tx_fsync),
        .route_en (hw_en),
        .pick     (pick),
        .sdata    (tx_data),
        .sen      (tx_en),
        .int_out  (int_out_w)
    );
endmodule

// File: tb/tb_pcm_tsi.sv
`timescale 1ns/1ps
module tb_pcm_tsi;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
    logic        tx_bclk = 1'b0, tx_fsync = 1'b0;
    logic [31:0] int_in = 32'h0;
    logic [31:0] route_cfg = 32'h0;
    logic        tx_data, tx_en;
    logic [31:0] int_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [7:0]  hold_m [8];
    logic [7:0]  stage_m [8];
    logic [7:0]  out_m [4];
    logic [3:0]  act_en_m = 4'h0;
    logic [31:0] exp_int = 32'hFFFF_FFFF;
    logic        exp_data = 1'b1, exp_en = 1'b0;
    logic [6:0]  rx_sr_m = 7'h0;
    int          rx_p = 255, tx_p = 255;
    bit          rx_lock_m = 1'b0, tx_lock_m = 1'b0, tx_arm_m = 1'b0;
    string       tx_tag = "R1 idle before sync";
    string       ph = "R4 routing";

    pcm_tsi dut (
        .clk(clk), .rst(rst),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_data(rx_data),
        .int_in(int_in), .route_cfg(route_cfg),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .tx_data(tx_data), .tx_en(tx_en), .int_out(int_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        chk(tx_tag, {30'd0, tx_en, tx_data}, {30'd0, exp_en, exp_data});
        chk("R3 R9 internal outputs", int_out, exp_int);
    endtask

    function automatic logic [7:0] pick_m(int o);
        logic [3:0] nib;
        nib = route_cfg[o*4 +: 4];
        return nib[3] ? hold_m[nib[2:0]] : 8'hFF;
    endfunction

    task automatic rise_evt(logic d, logic fs);
        int slot, b;
        rx_bclk = 1'b1; tx_bclk = 1'b1;
        rx_data = d; rx_fsync = fs; tx_fsync = fs;
        if (tx_arm_m) begin
            tx_arm_m = 1'b0; tx_lock_m = 1'b1; tx_p = 0;
            for (int o = 0; o < 4; o++) begin
                out_m[o]    = pick_m(o);
                act_en_m[o] = route_cfg[o*4+3];
            end
            for (int i = 0; i < 4; i++) exp_int[i*8 +: 8] = pick_m(4 + i);
        end else if (tx_p < 255) begin
            tx_p++;
        end
        slot = tx_p / 8;
        b    = tx_p % 8;
        if (tx_lock_m && slot < 4 && act_en_m[slot]) begin
            exp_en = 1'b1; exp_data = out_m[slot][7-b]; tx_tag = ph;
        end else begin
            exp_en = 1'b0; exp_data = 1'b1;
            tx_tag = (slot >= 4) ? "R7 slot beyond highway channels" : "R6 unrouted output";
        end
    endtask

    task automatic fall_evt();
        rx_bclk = 1'b0; tx_bclk = 1'b0;
        if (rx_fsync) begin
            for (int k = 0; k < 8; k++) hold_m[k] = stage_m[k];
            for (int i = 0; i < 4; i++) stage_m[4+i] = int_in[i*8 +: 8];
            rx_lock_m = 1'b1;
            rx_p = -1;
        end else begin
            if (rx_p < 255) rx_p++;
            if (rx_lock_m && (rx_p % 8) == 7 && (rx_p / 8) < 4)
                stage_m[rx_p/8] = {rx_sr_m, rx_data};
        end
        rx_sr_m = {rx_sr_m[5:0], rx_data};
        if (tx_fsync) tx_arm_m = 1'b1;
    endtask

    task automatic bit_cycle(logic d, logic fs);
        sample();
        rise_evt(d, fs);
        repeat (3) sample();
        sample();
        fall_evt();
        repeat (3) sample();
    endtask

    task automatic frame(int nslots, logic [31:0] hwv, logic [31:0] intv,
                         int chg_at, logic [31:0] newcfg);
        int nbits;
        nbits = nslots * 8;
        for (int p = 0; p < nbits; p++) begin
            int  slot;
            logic d;
            if (p == 5) int_in = intv;
            if (p == chg_at) route_cfg = newcfg;
            slot = p / 8;
            d = (slot < 4) ? hwv[slot*8 + 7 - (p % 8)] : ((p % 3) == 0);
            bit_cycle(d, p == nbits - 1);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin hold_m[k] = 8'hFF; stage_m[k] = 8'hFF; end
        for (int o = 0; o < 4; o++) out_m[o] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset serial", {30'd0, tx_en, tx_data}, 32'd1);
        chk("R1 reset internal", int_out, 32'hFFFF_FFFF);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 after release serial", {30'd0, tx_en, tx_data}, 32'd1);
        chk("R1 after release internal", int_out, 32'hFFFF_FFFF);

        // out0<-in6, out1<-in0, out2<-in3, out3 off, out4<-in6, out5<-in7, out6<-in1, out7<-in5
        route_cfg = 32'hD9FE_0B8E;
        ph = "R2 R4 R5 routing";
        frame(32, 32'hA53C_817E, 32'h1122_3344, -1, 32'h0);
        frame(32, 32'h0F96_C35A, 32'h5566_7788, -1, 32'h0);
        frame(32, 32'hFF00_8001, 32'h99AA_BBCC, -1, 32'h0);
        frame(32, 32'h6BD2_1E47, 32'hDDEE_F001, -1, 32'h0);

        ph = "R10 short frames";
        frame(8,  32'h1234_5678, 32'h0A0B_0C0D, -1, 32'h0);
        frame(8,  32'h9ABC_DEF0, 32'hA1B2_C3D4, -1, 32'h0);
        frame(16, 32'h3141_5926, 32'h2718_2818, -1, 32'h0);

        ph = "R8 mid-frame route change";
        frame(32, 32'hC0DE_BEEF, 32'h4455_6677, 20, 32'hAAAA_AAAA);
        ph = "R5 broadcast of one source";
        frame(32, 32'h8899_AABB, 32'h0102_0304, -1, 32'h0);
        frame(32, 32'h7766_5544, 32'h0506_0708, -1, 32'h0);

        route_cfg = 32'h0;
        ph = "R6 all outputs off";
        frame(32, 32'h5A5A_A5A5, 32'h1357_9BDF, -1, 32'h0);
        frame(8,  32'h2468_ACE0, 32'hFEDC_BA98, -1, 32'h0);

        route_cfg = 32'hD9FE_0B8E;
        ph = "R10 R4 return to routing";
        frame(16, 32'h0123_4567, 32'h89AB_CDEF, -1, 32'h0);
        frame(32, 32'hFEDC_BA98, 32'h7654_3210, -1, 32'h0);
        repeat (8) sample();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule